// File: doc/BRIEF.md
# Limit-Driven Control Output Unit

This block turns scanned input samples directly into control outputs, with no host in the loop. It has eight single-bit digital outputs and four 16-bit analog output codes. Each of these twelve outputs is bound to one input source by a source ID, and each has its own limit and hysteresis. Every sample carries a source ID, a kind (analog, digital port or counter) and a 32-bit value. When a sample arrives, every output bound to that source compares the value against its two thresholds, limit plus hysteresis and limit minus hysteresis, and updates a one-bit state that records whether the input is high or low.

Each output presents one of two programmed values, a "high" value or a "low" value, chosen by its state. The state bits also form a status word. The status word is always visible on a port. It is also placed into the sample stream that passes through the block: a sample whose source ID equals the reserved status ID has its data replaced by the status word. Because it uses that sample's existing slot, it adds no time to the scan.

Top module: `limit_ctrl_out`

## Requirements
- R1: After reset, and on every clock edge where `enable` is low, every state bit is 0, so every output shows its "low" value.
- R2: An output's state changes only on an edge where `enable` is high, `smp_valid` is high and `smp_src` equals that output's configured source. Any other sample, or no sample, leaves the state unchanged.
- R3: A matching sample whose value is strictly greater than limit plus hysteresis sets the state to 1. A value equal to that threshold leaves the state unchanged.
- R4: A matching sample whose value is strictly less than limit minus hysteresis clears the state to 0. A value equal to that threshold leaves the state unchanged.
- R5: A matching sample between the two thresholds, inclusive, holds the previous state.
- R6: When `smp_kind` is 0 (analog), the sample is bits [15:0] of `smp_data` taken as a signed 16-bit number. The limit is taken as a signed 32-bit number in that case.
- R7: When `smp_kind` is nonzero (1 = digital port, 2 = counter), the sample and the limit are unsigned 32-bit numbers. The hysteresis is always an unsigned 32-bit number. The threshold sums are formed without wrap-around.
- R8: `do_out[i]` equals `do_above[i]` when state i is 1 and `do_below[i]` otherwise. Analog output j, at bits [16j+15:16j] of `ao_out`, equals the matching slice of `ao_above` or `ao_below`, chosen by state 8+j.
- R9: `status_o` bit i is the state of digital output i, and bit 8+j is the state of analog output j. It reflects an update on the clock edge that samples the input.
- R10: The stream output repeats each input sample one cycle later (`st_valid`, `st_src`, `st_data`). When the source ID equals the status ID (15), the data is instead the zero-extended status word as it was before that edge.
- R11: Several outputs may be bound to the same source, and all of them are evaluated on the same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Unit enable; low forces all states to low |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_src | input | 4 | Source ID of the sample |
| smp_kind | input | 2 | 0 analog, 1 digital port, 2 counter |
| smp_data | input | 32 | Sample value |
| cfg_src | input | 48 | Source ID per output, 4 bits each, output k at [4k+3:4k] |
| cfg_limit | input | 384 | Limit per output, 32 bits each |
| cfg_hyst | input | 384 | Hysteresis per output, 32 bits each, unsigned |
| do_above | input | 8 | Digital output value when high |
| do_below | input | 8 | Digital output value when low |
| ao_above | input | 64 | Analog output codes when high |
| ao_below | input | 64 | Analog output codes when low |
| do_out | output | 8 | Digital control outputs |
| ao_out | output | 64 | Analog control output codes |
| status_o | output | 12 | Current output states |
| st_valid | output | 1 | Stream sample valid |
| st_src | output | 4 | Stream source ID |
| st_data | output | 32 | Stream data, with the status word substituted in the status slot |

## Verification
Random sample values are drawn close to each output's two thresholds, so that rising, falling and holding all occur often. These values are mixed across analog, digital and counter sources, some of which share outputs, and across unbound IDs and the status ID. Directed samples land exactly on each threshold, which separates a strict comparison from a non-strict one. Negative analog values and counter values at or above 2^31 show whether a signed or an unsigned comparison is in use. A limit near the top of the unsigned range shows whether the threshold sum wraps. Dropping `enable` in the middle of a run, and sending status-ID samples, check the forced-low behaviour and the word that is substituted into the stream.

// File: rtl/limit_ctrl_out.sv
module limit_ctrl_out #(
  parameter int N_DO       = 8,
  parameter int N_AO       = 4,
  parameter int SRC_W      = 4,
  parameter int AO_W       = 16,
  parameter int STATUS_SRC = 15,
  localparam int NOUT      = N_DO + N_AO
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  smp_valid,
  input  logic [SRC_W-1:0]      smp_src,
  input  logic [1:0]            smp_kind,
  input  logic [31:0]           smp_data,
  input  logic [NOUT*SRC_W-1:0] cfg_src,
  input  logic [NOUT*32-1:0]    cfg_limit,
  input  logic [NOUT*32-1:0]    cfg_hyst,
  input  logic [N_DO-1:0]       do_above,
  input  logic [N_DO-1:0]       do_below,
  input  logic [N_AO*AO_W-1:0]  ao_above,
  input  logic [N_AO*AO_W-1:0]  ao_below,
  output logic [N_DO-1:0]       do_out,
  output logic [N_AO*AO_W-1:0]  ao_out,
  output logic [NOUT-1:0]       status_o,
  output logic                  st_valid,
  output logic [SRC_W-1:0]      st_src,
  output logic [31:0]           st_data
);

  logic              is_analog;
  logic signed [33:0] x;
  logic [NOUT-1:0]   state, state_nx;

  assign is_analog = (smp_kind == 2'd0);
  assign x = is_analog ? {{18{smp_data[15]}}, smp_data[15:0]} : {2'b00, smp_data};

  for (genvar k = 0; k < NOUT; k++) begin : g_cmp
    logic [31:0]        lim_raw, hys_raw;
    logic signed [33:0] lim, hi_th, lo_th;
    logic               hit;

    assign lim_raw = cfg_limit[k*32 +: 32];
    assign hys_raw = cfg_hyst[k*32 +: 32];
    assign lim     = is_analog ? {{2{lim_raw[31]}}, lim_raw} : {2'b00, lim_raw};
    assign hi_th   = lim + $signed({2'b00, hys_raw});
    assign lo_th   = lim - $signed({2'b00, hys_raw});
    assign hit     = smp_valid && (smp_src == cfg_src[k*SRC_W +: SRC_W]);

    always_comb begin
      state_nx[k] = state[k];
      if (!enable)
        state_nx[k] = 1'b0;
      else if (hit && (x > hi_th))
        state_nx[k] = 1'b1;
      else if (hit && (x < lo_th))
        state_nx[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= '0;
    else        state <= state_nx;

  assign do_out   = (state[N_DO-1:0] & do_above) | (~state[N_DO-1:0] & do_below);
  assign status_o = state;

  for (genvar j = 0; j < N_AO; j++) begin : g_ao
    assign ao_out[j*AO_W +: AO_W] = state[N_DO+j] ? ao_above[j*AO_W +: AO_W]
                                                  : ao_below[j*AO_W +: AO_W];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_src   <= '0;
      st_data  <= '0;
    end else begin
      st_valid <= smp_valid;
      st_src   <= smp_src;
      st_data  <= (smp_src == SRC_W'(STATUS_SRC)) ? 32'(state) : smp_data;
    end

endmodule

// File: rtl/limit_ctrl_out_chk.sv
module limit_ctrl_out_chk #(
  parameter int N_DO       = 8,
  parameter int N_AO       = 4,
  parameter int SRC_W      = 4,
  parameter int STATUS_SRC = 15,
  localparam int NOUT      = N_DO + N_AO
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             smp_valid,
  input logic [SRC_W-1:0] smp_src,
  input logic [31:0]      smp_data,
  input logic [N_DO-1:0]  do_below,
  input logic [N_DO-1:0]  do_out,
  input logic [NOUT-1:0]  status_o,
  input logic             st_valid,
  input logic [31:0]      st_data
);

  // R1
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (status_o == '0));

  // R1
  disabled_do_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && $stable(do_below)) |=> (do_out == do_below));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !smp_valid) |=> $stable(status_o));

  // R10
  stream_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (st_valid == $past(smp_valid)));

  // R10
  stream_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_src != SRC_W'(STATUS_SRC)) |=> (st_data == $past(smp_data)));

  // R10
  stream_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_src == SRC_W'(STATUS_SRC)) |=> (st_data == 32'($past(status_o))));

endmodule

bind limit_ctrl_out limit_ctrl_out_chk #(
  .N_DO(N_DO), .N_AO(N_AO), .SRC_W(SRC_W), .STATUS_SRC(STATUS_SRC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
  .smp_src(smp_src), .smp_data(smp_data), .do_below(do_below),
  .do_out(do_out), .status_o(status_o), .st_valid(st_valid), .st_data(st_data)
);

// File: tb/test_limit_ctrl_out.sv
module test_limit_ctrl_out;
  localparam int NDO = 8, NAO = 4, NO = 12, SW = 4;

  logic clk = 0, rst_n = 0, enable = 0, smp_valid = 0;
  logic [SW-1:0] smp_src = 0;
  logic [1:0] smp_kind = 0;
  logic [31:0] smp_data = 0;
  logic [NO*SW-1:0] cfg_src;
  logic [NO*32-1:0] cfg_limit, cfg_hyst;
  logic [NDO-1:0] do_above = 8'hA5, do_below = 8'h5A;
  logic [NAO*16-1:0] ao_above = 64'h1111_2222_3333_4444, ao_below = 64'hAAAA_BBBB_CCCC_DDDD;
  logic [NDO-1:0] do_out;
  logic [NAO*16-1:0] ao_out;
  logic [NO-1:0] status_o;
  logic st_valid;
  logic [SW-1:0] st_src;
  logic [31:0] st_data;

  limit_ctrl_out i_limit_ctrl_out (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [NO-1:0] m_state = '0;
  logic [31:0] m_lim [NO];
  logic [31:0] m_hys [NO];
  logic [3:0] m_src [NO];
  logic exp_sv; logic [3:0] exp_ss; logic [31:0] exp_sd;

  function automatic logic [1:0] kind_of(input logic [3:0] s);
    case (s)
      4'd1, 4'd4: return 2'd0;
      4'd3:       return 2'd2;
      default:    return 2'd1;
    endcase
  endfunction

  function automatic logic next_st(input logic old, input logic [1:0] k,
                                   input logic [31:0] d, input logic [31:0] l, input logic [31:0] h);
    longint xv, lv;
    if (k == 0) begin xv = longint'($signed(d[15:0])); lv = longint'($signed(l)); end
    else        begin xv = longint'({32'd0, d});       lv = longint'({32'd0, l}); end
    if (xv > lv + longint'({32'd0, h})) return 1'b1;
    if (xv < lv - longint'({32'd0, h})) return 1'b0;
    return old;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [NDO-1:0] ed;
    logic [NAO*16-1:0] ea;
    ed = (m_state[NDO-1:0] & do_above) | (~m_state[NDO-1:0] & do_below);
    for (int j = 0; j < NAO; j++)
      ea[j*16 +: 16] = m_state[NDO+j] ? ao_above[j*16 +: 16] : ao_below[j*16 +: 16];
    chk({req, " R9 status"}, 64'(status_o), 64'(m_state));
    chk("R8 do_out", 64'(do_out), 64'(ed));
    chk("R8 ao_out", ao_out, ea);
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic v, input logic [3:0] s, input logic [31:0] d, input string req);
    smp_valid = v; smp_src = s; smp_kind = kind_of(s); smp_data = d;
    @(posedge clk);
    exp_sv = v; exp_ss = s;
    exp_sd = (s == 4'd15) ? 32'(m_state) : d;
    for (int k = 0; k < NO; k++)
      if (!enable) m_state[k] = 1'b0;
      else if (v && s == m_src[k])
        m_state[k] = next_st(m_state[k], kind_of(s), d, m_lim[k], m_hys[k]);
    @(negedge clk);
    check_all(req);
    chk("R10 st_valid", 64'(st_valid), 64'(exp_sv));
    if (exp_sv) begin
      chk("R10 st_src", 64'(st_src), 64'(exp_ss));
      chk("R10 st_data", 64'(st_data), 64'(exp_sd));
    end
  endtask

  task automatic setcfg(input int k, input logic [3:0] s, input logic [31:0] l, input logic [31:0] h);
    m_src[k] = s; m_lim[k] = l; m_hys[k] = h;
    cfg_src[k*SW +: SW] = s; cfg_limit[k*32 +: 32] = l; cfg_hyst[k*32 +: 32] = h;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 17;
    void'($urandom(seed));
    setcfg(0, 1, 100, 10);
    setcfg(1, 1, -50, 0);
    setcfg(2, 2, 32'h80, 4);
    setcfg(3, 3, 32'h8000_0000, 32'h100);
    setcfg(4, 1, 0, 1000);
    setcfg(5, 4, 32'h7FF0, 32'h10);
    setcfg(6, 3, 32'hFFFF_FFF0, 32'h20);
    setcfg(7, 0, 0, 0);
    setcfg(8, 1, 200, 20);
    setcfg(9, 2, 32'h40, 8);
    setcfg(10, 3, 32'h1000, 32'h10);
    setcfg(11, 5, 0, 0);
    @(negedge clk);
    check_all("R1 reset");
    rst_n = 1; enable = 1;
    @(negedge clk);

    // R3: exactly at upper threshold holds, one above sets
    step(1, 1, 110, "R3 equal hi");
    chk("R3 equal hi holds", 64'(status_o[0]), 0);
    step(1, 1, 111, "R3 above hi");
    chk("R3 set above hi", 64'(status_o[0]), 1);
    // R11: same sample drove outputs 1 and 8 as well
    chk("R11 shared src", 64'({status_o[8], status_o[1]}), 64'(2'b01));
    // R4: at lower threshold holds, below clears
    step(1, 1, 90, "R4 equal lo");
    chk("R4 equal lo holds", 64'(status_o[0]), 1);
    step(1, 1, 95, "R5 between");
    chk("R5 between holds", 64'(status_o[0]), 1);
    step(1, 1, 89, "R4 below lo");
    chk("R4 cleared", 64'(status_o[0]), 0);
    // R6: -100 signed is below -50
    step(1, 1, 32'hFFFF_FF9C, "R6 signed");
    chk("R6 analog signed", 64'(status_o[1]), 0);
    step(1, 1, 32'h0001_FFD0, "R6 low half only");
    chk("R6 upper bits ignored", 64'(status_o[1]), 1);
    // R7: counter unsigned
    step(1, 3, 32'h9000_0000, "R7 unsigned");
    chk("R7 counter unsigned", 64'(status_o[3]), 1);
    step(1, 3, 32'hFFFF_FFFF, "R7 no wrap");
    chk("R7 threshold no wrap", 64'(status_o[6]), 0);
    // R2: unbound source and idle cycles leave state
    step(1, 6, 32'hFFFF_FFFF, "R2 unbound");
    step(0, 1, 32'h7FFF, "R2 idle");
    chk("R2 idle no change", 64'(status_o[0]), 0);
    // R10: status slot
    step(1, 15, 32'hDEAD_BEEF, "R10 status slot");
    // R1: disable mid-run
    step(1, 3, 32'h9000_0000, "R7 set again");
    enable = 0;
    step(1, 3, 32'h9000_0000, "R1 disabled");
    chk("R1 disabled all low", 64'(status_o), 0);
    enable = 1;

    for (int n = 0; n < 3000; n++) begin
      int k; logic [3:0] s; logic [31:0] d, h; int r;
      k = $urandom % NO;
      r = $urandom % 10;
      if (r == 0) s = 4'(($urandom % 2) ? 15 : 6); else s = m_src[k];
      h = (m_hys[k] > 32'h400) ? 32'h400 : m_hys[k];
      d = m_lim[k] + 32'($urandom % (4*h + 5)) - (2*h + 2);
      if ($urandom % 8 == 0) d = $urandom;
      if ($urandom % 200 == 0) enable = ~enable;
      step(($urandom % 6) != 0, s, d, "R2 R3 R4 R5 R6 R7 R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule